// File: doc/BRIEF.md
# SDR SDRAM Power-Up Sequencer

This block brings a single-rank SDR SDRAM (a 32-bit bus built from two 16-bit devices) from power-on to a usable state. After reset it holds the clock enable high and drives NOP commands for a settling period. It then precharges every bank once, runs back-to-back auto-refresh commands for a fixed minimum time, and loads the mode register. After a final settling wait it raises `init_done`, deselects the device and hands the bus over to the normal-operation controller.

All device timings are given as parameters in tenths of a nanosecond and are turned into clock counts when the block is built. Each count is rounded up at the configured memory clock, which defaults to 60 MHz. After initialization the block keeps a periodic timer running and pulses `refresh_req` once per refresh interval, so that the main controller can schedule auto-refreshes.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `cke` is 0, and both `init_done` and `refresh_req` are 0.
- R2: After reset is released, `cke` is 1. The command {cs_n,ras_n,cas_n,we_n} is NOP (4'b0111) for the first PWRUP_US × CLK_MHZ − 1 cycles (5999 at the defaults).
- R3: In cycle PWRUP_US × CLK_MHZ (6000) after reset release, exactly one precharge-all (4'b0010) is issued, with `addr[10]` = 1 and all other address bits 0.
- R4: Auto-refresh (4'b0001) is issued ceil(max(ARF_US × CLK_MHZ, 129) / tRFC clocks) times (150 at the defaults). The first comes tRP clocks after the precharge, and each following one comes tRFC clocks after the one before it.
- R5: The mode-register load (4'b0000) comes tRFC clocks after the last auto-refresh. It drives `ba` = 0 and `addr` = 13'h032: CAS latency 3 in bits 6:4, sequential burst (bit 3 = 0), burst length 4 (code 2 in bits 2:0) and programmed write burst (bit 9 = 0).
- R6: `init_done` rises max(POST_US × CLK_MHZ, tMRD) cycles (600) after the mode-register load and never falls again until reset.
- R7: Once `init_done` is high, `cs_n` stays 1 (device deselected) and `cke` stays 1.
- R8: `refresh_req` is a one-cycle pulse. The first pulse comes floor(REFI_NS × CLK_MHZ / 1000) cycles (937) after `init_done` rises, and the pulses repeat at that spacing. It is never high before `init_done`.
- R9: Each nanosecond timing becomes ceil(ns × CLK_MHZ / 1000) clocks. At the defaults, tRP (20 ns) gives 2 clocks and tRFC (66 ns) gives 4 clocks.
- R10: Precharge-all, auto-refresh and mode load are the only commands other than NOP or deselect, and no two commands are issued in adjacent cycles during the auto-refresh burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address |
| init_done | output | 1 | Initialization complete, sticky |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
Two events can land on the same clock edge: the expiry of the tRFC wait that follows the last auto-refresh, and the end of the refresh count. That edge must produce a mode load rather than an extra refresh. The bench provokes this by running the whole burst and placing every expected command at its computed cycle in the scoreboard, so a refresh that is one too many or one too few shows up as a time or kind mismatch against the expected mode load. The rise of `init_done` and the restart of the refresh timer also share one edge, and this is judged by the position of the first `refresh_req` pulse.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_MHZ     = 60,
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int T_RP_NS10   = 200,
  parameter int T_RFC_NS10  = 660,
  parameter int T_MRD_CLK   = 2,
  parameter int PWRUP_US    = 100,
  parameter int ARF_US      = 10,
  parameter int ARF_MIN_CLK = 129,
  parameter int POST_US     = 10,
  parameter int REFI_NS     = 15625,
  parameter int CAS_LAT     = 3,
  parameter int BURST_CODE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req
);

  function automatic int ns10_to_clk(input int ns10);
    return (ns10 * CLK_MHZ + 9999) / 10000;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RP_CLK   = max2(ns10_to_clk(T_RP_NS10), 1);
  localparam int RFC_CLK  = max2(ns10_to_clk(T_RFC_NS10), 2);
  localparam int PWR_CLK  = max2(PWRUP_US * CLK_MHZ, 1);
  localparam int ARF_CLK  = max2(ARF_US * CLK_MHZ, ARF_MIN_CLK);
  localparam int ARF_N    = (ARF_CLK + RFC_CLK - 1) / RFC_CLK;
  localparam int POST_CLK = max2(POST_US * CLK_MHZ, T_MRD_CLK);
  localparam int REFI_CLK = max2(REFI_NS * CLK_MHZ / 1000, 2);
  localparam int CNT_MAX  = max2(max2(PWR_CLK, POST_CLK), max2(REFI_CLK, RFC_CLK + RP_CLK));
  localparam int CNT_W    = $clog2(CNT_MAX + 1) + 1;
  localparam int NREF_W   = $clog2(ARF_N + 1) + 1;

  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'((CAS_LAT << 4) | (BURST_CODE & 7));
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << 10;

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_PALL  = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_LMR   = 4'b0000;

  typedef enum logic [2:0] {PH_PWR, PH_PRE, PH_ARF, PH_MRS, PH_RUN} phase_t;

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [NREF_W-1:0] nref;
  logic [3:0]        cmd;
  logic              expired;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba      = '0;
  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_PWR;
      cnt         <= CNT_W'(PWR_CLK - 1);
      nref        <= '0;
      cmd         <= C_DESEL;
      cke         <= 1'b0;
      addr        <= '0;
      init_done   <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      cke         <= 1'b1;
      cmd         <= init_done ? C_DESEL : C_NOP;
      addr        <= '0;
      refresh_req <= 1'b0;
      cnt         <= cnt - 1'b1;
      case (ph)
        PH_PWR: if (expired) begin
          ph   <= PH_PRE;
          cmd  <= C_PALL;
          addr <= PALL_ADDR;
          cnt  <= CNT_W'(RP_CLK - 1);
        end
        PH_PRE: if (expired) begin
          ph   <= PH_ARF;
          cmd  <= C_REF;
          nref <= NREF_W'(ARF_N - 1);
          cnt  <= CNT_W'(RFC_CLK - 1);
        end
        PH_ARF: if (expired) begin
          if (nref == '0) begin
            ph   <= PH_MRS;
            cmd  <= C_LMR;
            addr <= MODE_WORD;
            cnt  <= CNT_W'(POST_CLK - 1);
          end else begin
            cmd  <= C_REF;
            nref <= nref - 1'b1;
            cnt  <= CNT_W'(RFC_CLK - 1);
          end
        end
        PH_MRS: if (expired) begin
          ph        <= PH_RUN;
          init_done <= 1'b1;
          cmd       <= C_DESEL;
          cnt       <= CNT_W'(REFI_CLK - 1);
        end
        default: if (expired) begin
          refresh_req <= 1'b1;
          cnt         <= CNT_W'(REFI_CLK - 1);
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              refresh_req
);
  logic is_pall, is_ref, is_lmr;
  assign is_pall = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_lmr  = !cs_n && !ras_n && !cas_n && !we_n;

  a_r2_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> cke);
  a_r3_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> addr[10]);
  a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> (addr == ADDR_W'(12'h032) && ba == '0));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r7_deselect_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cs_n && cke));
  a_r8_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);
  a_r10_ref_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> cs_n || (ras_n && cas_n && we_n));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ   = 60;
  localparam int PWR   = 100 * MHZ;
  localparam int RP    = (200 * MHZ + 9999) / 10000;
  localparam int RFC   = (660 * MHZ + 9999) / 10000;
  localparam int NREF  = ((10 * MHZ > 129 ? 10 * MHZ : 129) + RFC - 1) / RFC;
  localparam int POST  = 10 * MHZ;
  localparam int REFI  = 15625 * MHZ / 1000;
  localparam int LIMIT = 30000;

  typedef struct { int t; int kind; int addr; } ev_t;

  logic clk = 0, rst_n = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
  logic [1:0]  ba;
  logic [12:0] addr;

  sdram_powerup_seq uut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
    .refresh_req(refresh_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  ev_t q[$];

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int t, input int kind, input int a);
    ev_t e;
    e.t = t; e.kind = kind; e.addr = a;
    q.push_back(e);
  endtask

  task automatic drive_expected();
    int t;
    t = PWR;
    push(t, 2, 13'h400);
    t += RP;
    for (int k = 0; k < NREF; k++) begin
      push(t, 1, 0);
      t += RFC;
    end
    push(t, 0, 13'h032);
    t += POST;
    push(t, 16, 0);
    for (int k = 1; k <= 3; k++) push(t + k * REFI, 17, 0);
  endtask

  function automatic string tag(input int kind);
    case (kind)
      2: return "R3";
      1: return "R4";
      0: return "R5";
      16: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic match(input int n, input int kind, input int a);
    ev_t e;
    if (q.size() == 0) begin
      check("R10", 0, kind, -1);
      return;
    end
    e = q.pop_front();
    check(tag(e.kind), e.kind == kind, kind, e.kind);
    check(tag(e.kind), e.t == n, n, e.t);
    if (kind < 16) check(tag(e.kind), e.addr == a && ba == 2'b00, a, e.addr);
  endtask

  initial begin
    int n, t_done, t_pall, t_ref0, t_ref1, nrefs;
    bit prev_done, nop_ok, desel_ok;
    logic [3:0] c;
    n = 0; t_done = -1; t_pall = -1; t_ref0 = -1; t_ref1 = -1; nrefs = 0;
    prev_done = 0; nop_ok = 1; desel_ok = 1;
    drive_expected();
    repeat (3) @(negedge clk);
    check("R1", cs_n === 1'b1 && cke === 1'b0, {cs_n, cke}, 2);
    check("R1", init_done === 1'b0 && refresh_req === 1'b0, {init_done, refresh_req}, 0);
    rst_n = 1;
    while (n < LIMIT && !(t_done >= 0 && n >= t_done + 3 * REFI + 2)) begin
      @(negedge clk);
      n++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (n < PWR && !(c == 4'b0111 && cke)) nop_ok = 0;
      if (c != 4'b0111 && c != 4'b1111) begin
        match(n, int'(c), int'(addr));
        if (c == 4'b0010) t_pall = n;
        if (c == 4'b0001) begin
          if (nrefs == 0) t_ref0 = n;
          if (nrefs == 1) t_ref1 = n;
          nrefs++;
        end
      end
      if (init_done && !prev_done) begin
        match(n, 16, 0);
        t_done = n;
      end
      if (init_done && !(cs_n && cke)) desel_ok = 0;
      if (refresh_req) match(n, 17, 0);
      prev_done = init_done;
    end
    check("R2 watchdog", n < LIMIT, n, LIMIT);
    check("R2", nop_ok, nop_ok, 1);
    check("R7", desel_ok, desel_ok, 1);
    check("R9", t_ref0 - t_pall == 2, t_ref0 - t_pall, 2);
    check("R9", t_ref1 - t_ref0 == 4, t_ref1 - t_ref0, 4);
    check("R4", nrefs == 150, nrefs, 150);
    check("R10", q.size() == 0, q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule